// File: doc/BRIEF.md
# Multicore Boot and Reset Controller

This block is a small memory-mapped register file that governs reset and start-up of a four-core processor cluster. Software writes a control word, and the block acts only on the bits that differ from the stored word. A flipped per-core reset bit sends a one-cycle reset request to that core. A flipped enable bit, present for cores 1 to 3, sends a power-on request or a power-off request. A power-on request carries an entry address and an argument, both read from a pair of general-purpose registers.

Each core answers with a completion acknowledge. The block keeps one pending flag per core. The core's reset bit in the control word stays set until the acknowledge arrives, and only then is it cleared. Two peripheral soft-reset bits complete at once: writing a 1 gives a one-cycle pulse, and the bit reads back as 0. The block also holds a reset-status word, an interrupt-mask word and ten general-purpose words. These are plain storage. Reads are combinational.

Top module: `core_boot_ctrl`

## Requirements
- R1: After synchronous reset, index 0 (control) reads 0x521, index 2 (reset status) reads 0x1, index 4 (interrupt mask) reads 0x1F, and every other index below 16 reads 0.
- R2: The register index is bus_addr[11:2]. There are 16 words, indices 0 to 15. A write to any index from 1 to 15 stores the written word unchanged, and a read returns it in the same cycle.
- R3: A read with index 16 or above, or with bus_addr[1:0] not equal to 0, returns 0. Such a write changes no register.
- R4: A control write that flips bit 13+i (i = 0..3) pulses core_rst_req[i] high for exactly the cycle after the write edge. This applies unless R8 suppresses the pulse. Rewriting a bit with its stored value gives no pulse.
- R5: After a reset or enable request to core i, control bit 13+i keeps its written value until core_ack[i] is sampled high. It reads 0 from the cycle after that edge.
- R6: A control write that flips bit 21+k from 0 to 1 (k = 1..3) pulses core_on_req[k] for one cycle. During that pulse, core_on_entry word k holds general-purpose index 6+2k and core_on_arg word k holds index 7+2k, both as they were at the write. core_on_req[0] never rises.
- R7: A control write that flips bit 21+k from 1 to 0 pulses core_off_req[k] for one cycle.
- R8: When a write flips core k's enable bit, that write issues no reset request to core k, even if bit 13+k also flips. Bit 13+k is still stored as written and is cleared on core k's acknowledge.
- R9: Writing 1 to control bit 3 pulses periph_rst[0], and writing 1 to bit 12 pulses periph_rst[1], each for the cycle after the write. Both bits always read back as 0.
- R10: An acknowledge from a core with no pending request has no effect. It does not change the control word, and it does not satisfy a later request.
- R11: All other control bits are plain storage and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no valid read is present |
| core_ack | input | 4 | Per-core completion acknowledge |
| core_rst_req | output | 4 | Per-core reset request pulse |
| core_on_req | output | 4 | Per-core power-on request pulse |
| core_on_entry | output | 128 | Entry address, word k for core k |
| core_on_arg | output | 128 | Start argument, word k for core k |
| core_off_req | output | 4 | Per-core power-off request pulse |
| periph_rst | output | 2 | Peripheral soft-reset pulses |

## Verification
Read data is due in the same cycle as the address, so each read is checked 1 ns after the inputs are driven, before the next clock edge. Every request pulse, and the entry and argument values, is due in the single cycle after the write edge. A clear caused by an acknowledge is due in the cycle after the acknowledge edge. A reference model in the bench updates on each rising edge. The bench compares every output against that model at the following falling edge, so a pulse that arrives early, late or twice causes a mismatch. Directed reads then confirm the stored control bits, including reset bits that stay set while no acknowledge has been given.

// File: rtl/cbc_pkg.sv
// Shared constants for the boot and reset controller: register indices,
// control-word bit positions and reset values. Assumes 32-bit words.
package cbc_pkg;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_RSTAT = 2;
    localparam int IDX_IMASK = 4;
    localparam int IDX_GPR0  = 6;   // first general-purpose word

    localparam int B_PER1  = 3;     // peripheral 1 soft reset
    localparam int B_PER2  = 12;    // peripheral 2 soft reset
    localparam int B_CRST0 = 13;    // core 0 reset, cores 1..3 follow
    localparam int B_CEN1  = 22;    // core 1 enable, cores 2..3 follow

    localparam logic [31:0] CTRL_INIT  = 32'h0000_0521;
    localparam logic [31:0] RSTAT_INIT = 32'h0000_0001;
    localparam logic [31:0] IMASK_INIT = 32'h0000_001F;

    // Reset value of any word other than the control word.
    function automatic logic [31:0] word_init(input int idx);
        case (idx)
            IDX_RSTAT: return RSTAT_INIT;
            IDX_IMASK: return IMASK_INIT;
            default:   return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/cbc_core_track.sv
// Per-core pending tracker. It is set when a request is launched, and the
// next acknowledge clears it. An acknowledge while idle is dropped.
// Assumes launch and ack are synchronous single-cycle strobes.
module cbc_core_track (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic ack,
    output logic pend,
    output logic clr
);
    // an acknowledge is accepted only when a request is outstanding
    assign clr = ack & pend;

    // pending flag: set by launch, dropped by an accepted acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (launch) pend <= 1'b1;
        else if (clr)    pend <= 1'b0;
    end

    p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> pend);
    p_idle_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pend && !launch) |=> !pend);
endmodule

// File: rtl/cbc_regbank.sv
// Plain storage for words 1..NREG-1 and the combinational read mux.
// Assumes the caller has already decoded writes to non-control words.
module cbc_regbank import cbc_pkg::*; #(
    parameter int DW    = 32,
    parameter int NREG  = 16,
    parameter int NCORE = 4,
    parameter int IDXW  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [DW-1:0]             wdata,
    input  logic [IDXW-1:0]           rd_idx,
    input  logic [DW-1:0]             ctrl_q,
    output logic [DW-1:0]             rd_data,
    output logic [NCORE-1:0][DW-1:0]  boot_entry,
    output logic [NCORE-1:0][DW-1:0]  boot_arg
);
    logic [DW-1:0] words [1:NREG-1];

    // storage update: reset values, or the written word at its index
    always_ff @(posedge clk) begin
        for (int j = 1; j < NREG; j++) begin
            if (!rst_n)                              words[j] <= DW'(word_init(j));
            else if (wr_en && wr_idx == IDXW'(j))   words[j] <= wdata;
        end
    end

    // read mux: control word at index 0, stored words above, zero beyond
    always_comb begin
        rd_data = (rd_idx == '0) ? ctrl_q : '0;
        for (int j = 1; j < NREG; j++)
            if (rd_idx == IDXW'(j)) rd_data = words[j];
    end

    // entry/argument pair for each core that has an enable bit
    for (genvar c = 0; c < NCORE; c++) begin : g_pair
        if (c == 0) begin : g_none
            assign boot_entry[c] = '0;
            assign boot_arg[c]   = '0;
        end else begin : g_gpr
            assign boot_entry[c] = words[IDX_GPR0 + 2*c];
            assign boot_arg[c]   = words[IDX_GPR0 + 2*c + 1];
        end
    end
endmodule

// File: rtl/cbc_ctrl_reg.sv
// Control word with change-mask side effects. Flipped enable bits launch
// power-on or power-off, flipped reset bits launch resets, and peripheral
// bits pulse and store as 0. An accepted acknowledge clears the core's
// reset bit. Assumes one write per cycle at most.
module cbc_ctrl_reg import cbc_pkg::*; #(
    parameter int DW    = 32,
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    input  logic [NCORE-1:0] clr,
    output logic [DW-1:0]    ctrl_q,
    output logic [NCORE-1:0] launch,
    output logic [NCORE-1:0] on_fire,
    output logic [NCORE-1:0] rst_pulse,
    output logic [NCORE-1:0] on_pulse,
    output logic [NCORE-1:0] off_pulse,
    output logic [1:0]       periph_pulse
);
    logic [NCORE-1:0] en_chg, en_new, rst_chg;
    logic [DW-1:0]    nxt;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        if (c == 0) begin : g_noen
            assign en_chg[c] = 1'b0;
            assign en_new[c] = 1'b0;
        end else begin : g_en
            assign en_chg[c] = wr_en & (ctrl_q[B_CEN1+c-1] ^ wdata[B_CEN1+c-1]);
            assign en_new[c] = wdata[B_CEN1+c-1];
        end
        // an enable change takes over the reset bit for this write
        assign rst_chg[c] = wr_en & (ctrl_q[B_CRST0+c] ^ wdata[B_CRST0+c]) & ~en_chg[c];

        p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[c] && !wr_en) |=> !ctrl_q[B_CRST0+c]);
        p_enable_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (on_pulse[c] || off_pulse[c]) |-> !rst_pulse[c]);
        p_on_off_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(on_pulse[c] && off_pulse[c]));
    end

    assign launch  = en_chg | rst_chg;
    assign on_fire = en_chg & en_new;

    // next control value: written word with peripheral bits dropped, then ack clears
    always_comb begin
        nxt = ctrl_q;
        if (wr_en) begin
            nxt         = wdata;
            nxt[B_PER1] = 1'b0;
            nxt[B_PER2] = 1'b0;
        end
        for (int c = 0; c < NCORE; c++)
            if (clr[c]) nxt[B_CRST0+c] = 1'b0;
    end

    // control word and single-cycle request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= DW'(CTRL_INIT);
            rst_pulse    <= '0;
            on_pulse     <= '0;
            off_pulse    <= '0;
            periph_pulse <= '0;
        end else begin
            ctrl_q       <= nxt;
            rst_pulse    <= rst_chg;
            on_pulse     <= en_chg & en_new;
            off_pulse    <= en_chg & ~en_new;
            periph_pulse <= {wr_en & wdata[B_PER2], wr_en & wdata[B_PER1]};
        end
    end

    p_periph_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[B_PER1] && !ctrl_q[B_PER2]);
    p_periph_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> periph_pulse == 2'b00);
endmodule

// File: rtl/core_boot_ctrl.sv
// Top of the boot and reset controller. It decodes a 4 KiB word-aligned
// register window and wires the control word, the storage and the per-core
// trackers together. The entry address and argument are latched with each
// power-on request. Assumes aligned 32-bit accesses and single-cycle strobes.
module core_boot_ctrl import cbc_pkg::*; #(
    parameter int DW    = 32,
    parameter int AW    = 12,
    parameter int NREG  = 16,
    parameter int NCORE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NCORE-1:0]    core_ack,
    output logic [NCORE-1:0]    core_rst_req,
    output logic [NCORE-1:0]    core_on_req,
    output logic [NCORE*DW-1:0] core_on_entry,
    output logic [NCORE*DW-1:0] core_on_arg,
    output logic [NCORE-1:0]    core_off_req,
    output logic [1:0]          periph_rst
);
    localparam int IDXW = AW - 2;

    logic [IDXW-1:0]          idx;
    logic                     aligned, in_range, wr_ctrl, wr_other;
    logic [DW-1:0]            ctrl_q, rd_word;
    logic [NCORE-1:0]         launch, on_fire, clr, pend;
    logic [NCORE-1:0][DW-1:0] boot_entry, boot_arg;

    assign idx      = bus_addr[AW-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_range = aligned && (idx < IDXW'(NREG));
    assign wr_ctrl  = bus_valid && bus_we && in_range && (idx == IDXW'(IDX_CTRL));
    assign wr_other = bus_valid && bus_we && in_range && (idx != IDXW'(IDX_CTRL));
    assign bus_rdata = (bus_valid && !bus_we && in_range) ? rd_word : '0;

    cbc_ctrl_reg #(.DW(DW), .NCORE(NCORE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata), .clr(clr),
        .ctrl_q(ctrl_q), .launch(launch), .on_fire(on_fire),
        .rst_pulse(core_rst_req), .on_pulse(core_on_req), .off_pulse(core_off_req),
        .periph_pulse(periph_rst)
    );

    cbc_regbank #(.DW(DW), .NREG(NREG), .NCORE(NCORE), .IDXW(IDXW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_other), .wr_idx(idx), .wdata(bus_wdata),
        .rd_idx(idx), .ctrl_q(ctrl_q), .rd_data(rd_word),
        .boot_entry(boot_entry), .boot_arg(boot_arg)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_trk
        cbc_core_track u_trk (
            .clk(clk), .rst_n(rst_n), .launch(launch[c]), .ack(core_ack[c]),
            .pend(pend[c]), .clr(clr[c])
        );

        // capture the boot pair at the write that powers the core on
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                core_on_entry[c*DW +: DW] <= '0;
                core_on_arg[c*DW +: DW]   <= '0;
            end else if (on_fire[c]) begin
                core_on_entry[c*DW +: DW] <= boot_entry[c];
                core_on_arg[c*DW +: DW]   <= boot_arg[c];
            end
        end
    end

    p_oob_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && !in_range) |-> bus_rdata == '0);
    p_core0_never_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_on_req[0] && !core_off_req[0]);
    p_req_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_req != '0) |-> ((core_rst_req & ~pend) == '0));
endmodule

// File: tb/core_boot_ctrl_test.sv
`timescale 1ns/1ps
module core_boot_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0, bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   core_ack = '0;
    logic [3:0]   core_rst_req, core_on_req, core_off_req;
    logic [127:0] core_on_entry, core_on_arg;
    logic [1:0]   periph_rst;

    int checks = 0, errors = 0;
    bit live = 0, done = 0;

    always #2 clk = ~clk;  // 250 MHz

    core_boot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_ack(core_ack), .core_rst_req(core_rst_req), .core_on_req(core_on_req),
        .core_on_entry(core_on_entry), .core_on_arg(core_on_arg),
        .core_off_req(core_off_req), .periph_rst(periph_rst)
    );

    // behavioural reference model
    logic [31:0] m_ctrl;
    logic [31:0] m_word [16];
    bit   [3:0]  m_pend;
    logic [3:0]  e_rst, e_on, e_off;
    logic [1:0]  e_per;
    logic [31:0] e_entry [4];
    logic [31:0] e_arg [4];

    task automatic model_reset();
        m_ctrl = 32'h521;
        for (int j = 0; j < 16; j++) m_word[j] = 0;
        m_word[2] = 32'h1;
        m_word[4] = 32'h1F;
        m_pend = '0; e_rst = '0; e_on = '0; e_off = '0; e_per = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit [3:0] took, skip;
            took = core_ack & m_pend;
            e_rst = '0; e_on = '0; e_off = '0; e_per = '0; skip = '0;
            m_pend = m_pend & ~took;
            if (bus_valid && bus_we && bus_addr[1:0] == 2'b00 && bus_addr[11:2] < 16) begin
                if (bus_addr[11:2] == 0) begin
                    logic [31:0] ch;
                    ch = m_ctrl ^ bus_wdata;
                    for (int k = 1; k < 4; k++) if (ch[21+k]) begin
                        skip[k] = 1; m_pend[k] = 1;
                        if (bus_wdata[21+k]) begin
                            e_on[k] = 1; e_entry[k] = m_word[6+2*k]; e_arg[k] = m_word[7+2*k];
                        end else e_off[k] = 1;
                    end
                    for (int i = 0; i < 4; i++) if (ch[13+i] && !skip[i]) begin
                        e_rst[i] = 1; m_pend[i] = 1;
                    end
                    e_per = {bus_wdata[12], bus_wdata[3]};
                    m_ctrl = bus_wdata & ~32'h0000_1008;
                end else m_word[bus_addr[11:2]] = bus_wdata;
            end
            for (int i = 0; i < 4; i++) if (took[i]) m_ctrl[13+i] = 1'b0;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of every pulse output against the model
    always @(negedge clk) if (live) begin
        check("R4 core_rst_req", core_rst_req, e_rst);
        check("R6 core_on_req", core_on_req, e_on);
        check("R7 core_off_req", core_off_req, e_off);
        check("R9 periph_rst", periph_rst, e_per);
        for (int k = 1; k < 4; k++) if (e_on[k]) begin
            check("R6 entry", core_on_entry[k*32 +: 32], e_entry[k]);
            check("R6 arg", core_on_arg[k*32 +: 32], e_arg[k]);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_we = 0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1; bus_we = 0; bus_addr = a;
        #1 check(req, bus_rdata, exp);
        bus_valid = 0;
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk);
        core_ack = m;
        @(negedge clk);
        core_ack = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        live = 1;
        // R1 reset state
        rd("R1 ctrl", 12'h000, 32'h521);
        rd("R1 status", 12'h008, 32'h1);
        rd("R1 mask", 12'h010, 32'h1F);
        rd("R1 gpr", 12'h020, 32'h0);
        // R2 storage of general-purpose words
        for (int j = 6; j < 16; j++) wr(12'(j*4), 32'hA500_0000 + j*32'h111);
        wr(12'h008, 32'h0000_00F0);
        for (int j = 6; j < 16; j++) rd("R2 gpr readback", 12'(j*4), m_word[j]);
        rd("R2 status write", 12'h008, 32'hF0);
        // R3 out of range and misaligned
        wr(12'h040, 32'hDEAD_BEEF);
        wr(12'hFFC, 32'hDEAD_BEEF);
        wr(12'h021, 32'h1234_5678);
        rd("R3 oob read", 12'h040, 32'h0);
        rd("R3 top read", 12'hFFC, 32'h0);
        rd("R3 misaligned read", 12'h022, 32'h0);
        rd("R3 gpr untouched", 12'h020, 32'hA500_0000 + 8*32'h111);
        rd("R3 ctrl untouched", 12'h000, 32'h521);
        // R4/R5 core 0 reset held until acknowledge
        wr(12'h000, 32'h521 | (1 << 13));
        idle(4);
        rd("R5 bit held", 12'h000, 32'h521 | (1 << 13));
        ack(4'b0001);
        rd("R5 bit cleared", 12'h000, 32'h521);
        // R4 rewrite of same value gives no pulse
        wr(12'h000, 32'h521);
        // R10 spurious acknowledge, then a real request waits for a fresh ack
        ack(4'b0100);
        rd("R10 ctrl unchanged", 12'h000, 32'h521);
        wr(12'h000, 32'h521 | (1 << 15));
        idle(3);
        rd("R10 bit still held", 12'h000, 32'h521 | (1 << 15));
        ack(4'b0100);
        rd("R10 cleared by real ack", 12'h000, 32'h521);
        // R6/R8 enable core 1 with its reset bit flipping too
        wr(12'h000, 32'h521 | (1 << 22) | (1 << 14));
        idle(2);
        rd("R8 bit stored", 12'h000, 32'h521 | (1 << 22) | (1 << 14));
        ack(4'b0010);
        rd("R8 bit cleared", 12'h000, 32'h521 | (1 << 22));
        // R7 disable core 1
        wr(12'h000, 32'h521);
        ack(4'b0010);
        // R6 cores 2 and 3 together, new pair for core 3
        wr(12'h030, 32'h8000_0300);
        wr(12'h000, 32'h521 | (3 << 23));
        ack(4'b1100);
        wr(12'h000, 32'h521);
        ack(4'b1100);
        // R9 peripheral soft resets
        wr(12'h000, 32'h521 | 32'h1008);
        rd("R9 bits stored zero", 12'h000, 32'h521);
        wr(12'h000, 32'h521 | 32'h0008);
        // R11 plain storage bits
        wr(12'h000, 32'hF000_0A40);
        rd("R11 storage", 12'h000, 32'hF000_0A40);
        wr(12'h000, 32'h521);
        ack(4'b1111);
        idle(4);
        rd("R11 restored", 12'h000, 32'h521);
        live = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule